// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block picks the divider settings of a clock synthesizer so that its output comes as close as possible to a requested frequency. Software gives the request, the reference frequency, the legal oscillator window and the fastest output clock allowed, then pulses `start`. The engine limits the request to what the synthesizer can reach. It then tries every candidate pair of output divider P and reference divider M. For each pair it derives the feedback multiplier N and keeps the pair whose output frequency lands nearest to the request.

Every quantity is an unsigned integer in kHz. A single iterative divider handles both divisions that each candidate needs, so one candidate costs a few dozen cycles, and a full search over all pairs stays within a few thousand cycles. When the search ends, the engine pulses `done` and shows the winning M, N and encoded P. It also shows the resulting frequency and a packed 24-bit word that can be written straight into the synthesizer's control register. If no candidate qualifies, the engine raises `no_fit` together with `done` and leaves its previous results unchanged.

Top module: `pll_search`

## Requirements
- R1: The working request is first raised to `vco_min_khz >> 4` if it is below that value, and then lowered to `out_max_khz` if it is above that value. When the two limits conflict, the upper limit wins.
- R2: Output divider values 1, 2, 4, 8 and 16 are tried in ascending order. A value P is skipped unless (working request × P) lies in [`vco_min_khz`, `vco_max_khz`], bounds included.
- R3: For each P that is not skipped, M is tried from 7 up to 14. An M is skipped unless 1000×M ≤ `ref_khz` ≤ 2000×M, which is the exact form of the condition that the phase-detector frequency lies between 1 and 2 MHz inclusive.
- R4: N = floor((2 × request × P × M + ref) / (2 × ref)), which is the quotient rounded to nearest. A candidate with N = 0 or N > 255 is discarded.
- R5: Achieved frequency = floor(ref × N / (M × P)), and error = |request − achieved|. The kept candidate is replaced only by a strictly smaller error, so on a tie the candidate tried earlier stays.
- R6: `p_code` carries log2(P): 1→0, 2→1, 4→2, 8→3, 16→4.
- R7: `pll_word` is {P code zero-extended to 8 bits in bits 23:16, N in bits 15:8, M zero-extended in bits 7:0}. `m_val`, `n_val` and `achieved_khz` show the same winning candidate.
- R8: `done` is high for exactly one cycle at the end of each search. The result outputs change only in that cycle and hold their values at all other times.
- R9: If no candidate qualifies, `done` is raised with `no_fit` = 1, and M, N, P code, achieved frequency and `pll_word` keep the values from before. `no_fit` is 0 in every `done` cycle where a result was found.
- R10: `busy` is high from the cycle after an accepted `start` until `done`, and `busy` is low in the `done` cycle. A `start` while `busy` is high is ignored, and the running search completes with its original request.
- R11: After reset, `busy`, `done` and `no_fit` are 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle |
| req_khz | input | 32 | Requested output frequency, latched at start |
| ref_khz | input | 32 | Reference frequency, held stable during a search |
| vco_min_khz | input | 32 | Lowest legal oscillator frequency |
| vco_max_khz | input | 32 | Highest legal oscillator frequency |
| out_max_khz | input | 32 | Highest output clock allowed |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| no_fit | output | 1 | With done: no candidate qualified |
| m_val | output | 8 | Winning reference divider M |
| n_val | output | 8 | Winning feedback multiplier N |
| p_code | output | 3 | log2 of winning output divider P |
| achieved_khz | output | 32 | Output frequency of the winning setting |
| pll_word | output | 24 | Packed register word {P code, N, M} |

## Verification
Two things can happen in the same cycle: the search finishes, and a new `start` arrives or the no-fit path must hold the results. The bench sends a second `start` with a different request while a search is in progress. It then checks that the busy flag stays up and that the reported result matches the original request. A no-fit search is run right after a good one, and the bench checks that `done` and `no_fit` rise together while the packed word still holds the earlier result. A request whose exact error of zero is reached by two values of M checks that the earlier candidate is kept.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PSTEP,
        S_MSTEP,
        S_DIVN,
        S_DIVA,
        S_FINISH
    } srch_state_e;

endpackage

// File: rtl/pll_clamp.sv
module pll_clamp #(
    parameter int FREQ_W = 32,
    parameter int K_MAX  = 4
) (
    input  logic [FREQ_W-1:0] req_in,
    input  logic [FREQ_W-1:0] vco_min,
    input  logic [FREQ_W-1:0] out_max,
    output logic [FREQ_W-1:0] req_out
);
    logic [FREQ_W-1:0] floor_lim;
    logic [FREQ_W-1:0] raised;

    always_comb begin
        floor_lim = vco_min >> K_MAX;
        raised    = (req_in < floor_lim) ? floor_lim : req_in;
        req_out   = (raised > out_max) ? out_max : raised;
    end
endmodule

// File: rtl/pll_div.sv
module pll_div #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             fin
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic             fin;
    } div_t;

    div_t dv_d, dv_q;
    logic [DEN_W:0] rem_sh;
    logic [DEN_W:0] trial;

    always_comb begin
        dv_d     = dv_q;
        dv_d.fin = 1'b0;
        rem_sh   = {dv_q.rem, dv_q.quo[NUM_W-1]};
        trial    = rem_sh - {1'b0, den};
        if (go) begin
            dv_d.busy = 1'b1;
            dv_d.cnt  = CNT_W'(NUM_W);
            dv_d.rem  = '0;
            dv_d.quo  = num;
        end else if (dv_q.busy) begin
            dv_d.quo = {dv_q.quo[NUM_W-2:0], ~trial[DEN_W]};
            dv_d.rem = trial[DEN_W] ? rem_sh[DEN_W-1:0] : trial[DEN_W-1:0];
            dv_d.cnt = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CNT_W'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign quo = dv_q.quo;
    assign fin = dv_q.fin;
endmodule

// File: rtl/pll_search.sv
module pll_search #(
    parameter int FREQ_W    = 32,
    parameter int M_LO      = 7,
    parameter int M_HI      = 14,
    parameter int K_MAX     = 4,
    parameter int PD_LO_KHZ = 1000,
    parameter int PD_HI_KHZ = 2000,
    parameter int N_MAX     = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_khz,
    input  logic [FREQ_W-1:0] ref_khz,
    input  logic [FREQ_W-1:0] vco_min_khz,
    input  logic [FREQ_W-1:0] vco_max_khz,
    input  logic [FREQ_W-1:0] out_max_khz,
    output logic              busy,
    output logic              done,
    output logic              no_fit,
    output logic [7:0]        m_val,
    output logic [7:0]        n_val,
    output logic [2:0]        p_code,
    output logic [FREQ_W-1:0] achieved_khz,
    output logic [23:0]       pll_word
);
    import pll_search_pkg::*;

    localparam int MW    = $clog2(M_HI + 1);
    localparam int KW    = $clog2(K_MAX + 1);
    localparam int NW    = $clog2(N_MAX + 1);
    localparam int VCO_W = FREQ_W + K_MAX;
    localparam int NUM_W = FREQ_W + 8;
    localparam int DEN_W = FREQ_W + 1;

    typedef struct packed {
        srch_state_e       st;
        logic [FREQ_W-1:0] req;
        logic [KW-1:0]     k;
        logic [MW-1:0]     m;
        logic [NW-1:0]     n;
        logic              go;
        logic              found;
        logic [NUM_W-1:0]  best_err;
        logic [MW-1:0]     best_m;
        logic [NW-1:0]     best_n;
        logic [KW-1:0]     best_k;
        logic [NUM_W-1:0]  best_ach;
        logic [MW-1:0]     out_m;
        logic [NW-1:0]     out_n;
        logic [KW-1:0]     out_k;
        logic [FREQ_W-1:0] out_ach;
        logic              done;
        logic              no_fit;
    } srch_t;

    srch_t s_d, s_q;

    logic [FREQ_W-1:0] req_clamped;
    logic [VCO_W-1:0]  vco_w;
    logic [NUM_W-1:0]  num_n, num_a, div_num, div_quo;
    logic [DEN_W-1:0]  den_n, den_a, div_den;
    logic [NUM_W-1:0]  pd_lo_lim, pd_hi_lim, err_now;
    logic              div_fin;

    pll_clamp #(.FREQ_W(FREQ_W), .K_MAX(K_MAX)) u_clamp (
        .req_in  (req_khz),
        .vco_min (vco_min_khz),
        .out_max (out_max_khz),
        .req_out (req_clamped)
    );

    always_comb begin
        vco_w     = VCO_W'(s_q.req) << s_q.k;
        num_n     = ((NUM_W'(vco_w) * NUM_W'(s_q.m)) << 1) + NUM_W'(ref_khz);
        den_n     = {ref_khz, 1'b0};
        num_a     = NUM_W'(ref_khz) * NUM_W'(s_q.n);
        den_a     = DEN_W'(DEN_W'(s_q.m) << s_q.k);
        div_num   = (s_q.st == S_DIVA) ? num_a : num_n;
        div_den   = (s_q.st == S_DIVA) ? den_a : den_n;
        pd_lo_lim = NUM_W'(PD_LO_KHZ) * NUM_W'(s_q.m);
        pd_hi_lim = NUM_W'(PD_HI_KHZ) * NUM_W'(s_q.m);
        err_now   = (NUM_W'(s_q.req) >= div_quo) ? NUM_W'(s_q.req) - div_quo
                                                 : div_quo - NUM_W'(s_q.req);
    end

    pll_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (s_q.go),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .fin   (div_fin)
    );

    always_comb begin
        logic adv_m;
        logic adv_p;
        s_d        = s_q;
        s_d.go     = 1'b0;
        s_d.done   = 1'b0;
        s_d.no_fit = 1'b0;
        adv_m      = 1'b0;
        adv_p      = 1'b0;
        unique case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.req   = req_clamped;
                    s_d.k     = '0;
                    s_d.found = 1'b0;
                    s_d.st    = S_PSTEP;
                end
            end
            S_PSTEP: begin
                if (vco_w >= VCO_W'(vco_min_khz) && vco_w <= VCO_W'(vco_max_khz)) begin
                    s_d.m  = MW'(M_LO);
                    s_d.st = S_MSTEP;
                end else begin
                    adv_p = 1'b1;
                end
            end
            S_MSTEP: begin
                if (NUM_W'(ref_khz) >= pd_lo_lim && NUM_W'(ref_khz) <= pd_hi_lim) begin
                    s_d.go = 1'b1;
                    s_d.st = S_DIVN;
                end else begin
                    adv_m = 1'b1;
                end
            end
            S_DIVN: begin
                if (div_fin) begin
                    if (div_quo != '0 && div_quo <= NUM_W'(N_MAX)) begin
                        s_d.n  = NW'(div_quo);
                        s_d.go = 1'b1;
                        s_d.st = S_DIVA;
                    end else begin
                        adv_m = 1'b1;
                    end
                end
            end
            S_DIVA: begin
                if (div_fin) begin
                    if (!s_q.found || err_now < s_q.best_err) begin
                        s_d.found    = 1'b1;
                        s_d.best_err = err_now;
                        s_d.best_m   = s_q.m;
                        s_d.best_n   = s_q.n;
                        s_d.best_k   = s_q.k;
                        s_d.best_ach = div_quo;
                    end
                    adv_m = 1'b1;
                end
            end
            S_FINISH: begin
                s_d.done = 1'b1;
                s_d.st   = S_IDLE;
                if (s_q.found) begin
                    s_d.out_m   = s_q.best_m;
                    s_d.out_n   = s_q.best_n;
                    s_d.out_k   = s_q.best_k;
                    s_d.out_ach = FREQ_W'(s_q.best_ach);
                end else begin
                    s_d.no_fit = 1'b1;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
        if (adv_m) begin
            if (s_q.m == MW'(M_HI)) begin
                adv_p = 1'b1;
            end else begin
                s_d.m  = s_q.m + 1'b1;
                s_d.st = S_MSTEP;
            end
        end
        if (adv_p) begin
            if (s_q.k == KW'(K_MAX)) begin
                s_d.st = S_FINISH;
            end else begin
                s_d.k  = s_q.k + 1'b1;
                s_d.st = S_PSTEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy         = (s_q.st != S_IDLE);
    assign done         = s_q.done;
    assign no_fit       = s_q.no_fit;
    assign m_val        = 8'(s_q.out_m);
    assign n_val        = 8'(s_q.out_n);
    assign p_code       = 3'(s_q.out_k);
    assign achieved_khz = s_q.out_ach;
    assign pll_word     = {8'(s_q.out_k), 8'(s_q.out_n), 8'(s_q.out_m)};
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
    parameter int M_LO  = 7,
    parameter int M_HI  = 14,
    parameter int K_MAX = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        no_fit,
    input logic [7:0]  m_val,
    input logic [7:0]  n_val,
    input logic [2:0]  p_code,
    input logic [23:0] pll_word
);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pll_word));
    a_r9_nofit_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        no_fit |-> done);
    a_r9_nofit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_fit) |-> $stable(pll_word));
    a_r3_m_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_fit) |-> (m_val >= 8'(M_LO) && m_val <= 8'(M_HI)));
    a_r4_n_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_fit) |-> (n_val != 8'd0));
    a_r6_p_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_fit) |-> (p_code <= 3'(K_MAX)));
    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pll_search pll_search_chk #(.M_LO(M_LO), .M_HI(M_HI), .K_MAX(K_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .no_fit   (no_fit),
    .m_val    (m_val),
    .n_val    (n_val),
    .p_code   (p_code),
    .pll_word (pll_word)
);

// File: tb/pll_search_bench.sv
module pll_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_khz = '0, ref_khz = '0, vco_min_khz = '0, vco_max_khz = '0, out_max_khz = '0;
    logic        busy, done, no_fit;
    logic [7:0]  m_val, n_val;
    logic [2:0]  p_code;
    logic [31:0] achieved_khz;
    logic [23:0] pll_word;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pll_search u_pll_search (
        .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz), .ref_khz(ref_khz),
        .vco_min_khz(vco_min_khz), .vco_max_khz(vco_max_khz), .out_max_khz(out_max_khz),
        .busy(busy), .done(done), .no_fit(no_fit), .m_val(m_val), .n_val(n_val),
        .p_code(p_code), .achieved_khz(achieved_khz), .pll_word(pll_word)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model(input longint rq, input longint rf, input longint vmn,
                                  input longint vmx, input longint omx,
                                  output bit fnd, output longint bm, output longint bn,
                                  output longint bk, output longint ba);
        longint lo, r, vco, n, a, e, be;
        lo = vmn >> 4;
        r = rq;
        if (r < lo) r = lo;
        if (r > omx) r = omx;
        fnd = 0; be = 0; bm = 0; bn = 0; bk = 0; ba = 0;
        for (int k = 0; k <= 4; k++) begin
            vco = r << k;
            if (vco >= vmn && vco <= vmx) begin
                for (int m = 7; m <= 14; m++) begin
                    if (1000 * m <= rf && rf <= 2000 * m) begin
                        n = (2 * vco * m + rf) / (2 * rf);
                        if (n >= 1 && n <= 255) begin
                            a = (rf * n) / (longint'(m) << k);
                            e = (r > a) ? r - a : a - r;
                            if (!fnd || e < be) begin
                                fnd = 1; be = e; bm = m; bn = n; bk = k; ba = a;
                            end
                        end
                    end
                end
            end
        end
    endfunction

    task automatic kick(input longint rq, input longint rf, input longint vmn,
                        input longint vmx, input longint omx);
        @(negedge clk);
        req_khz = 32'(rq); ref_khz = 32'(rf); vco_min_khz = 32'(vmn);
        vco_max_khz = 32'(vmx); out_max_khz = 32'(omx);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk({tag, " done seen"}, done, 1);
    endtask

    task automatic check_result(input string tag, input longint rq, input longint rf,
                                input longint vmn, input longint vmx, input longint omx);
        bit fnd;
        longint bm, bn, bk, ba;
        model(rq, rf, vmn, vmx, omx, fnd, bm, bn, bk, ba);
        chk({tag, " R9 no_fit"}, no_fit, fnd ? 0 : 1);
        chk({tag, " R5 m"}, m_val, bm);
        chk({tag, " R4 n"}, n_val, bn);
        chk({tag, " R6 p_code"}, p_code, bk);
        chk({tag, " R5 achieved"}, achieved_khz, ba);
        chk({tag, " R7 word"}, pll_word, (bk << 16) | (bn << 8) | bm);
    endtask

    task automatic t_reset();
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 no_fit", no_fit, 0);
        chk("R11 word", pll_word, 0);
        chk("R11 achieved", achieved_khz, 0);
    endtask

    task automatic t_normal(input string tag, input longint rq);
        kick(rq, 14318, 128000, 350000, 350000);
        chk({tag, " R10 busy after start"}, busy, 1);
        wait_done(tag);
        check_result(tag, rq, 14318, 128000, 350000, 350000);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, done, 0);
    endtask

    task automatic t_clamp_low();
        kick(1000, 14318, 128000, 350000, 350000);
        wait_done("R1 low");
        check_result("R1 low", 1000, 14318, 128000, 350000, 350000);
        chk("R1 low clamp uses P=16", p_code, 4);
    endtask

    task automatic t_clamp_high();
        kick(500000, 14318, 128000, 350000, 300000);
        wait_done("R1 high");
        check_result("R1 high", 500000, 14318, 128000, 350000, 300000);
        chk("R1 R2 high clamp uses P=1", p_code, 0);
    endtask

    task automatic t_tie();
        kick(100000, 14000, 128000, 350000, 350000);
        wait_done("R5 tie");
        chk("R5 tie keeps first M", m_val, 7);
        chk("R5 tie N", n_val, 100);
        chk("R2 tie P code", p_code, 1);
        chk("R7 tie word", pll_word, 24'h016407);
        chk("R5 tie achieved", achieved_khz, 100000);
    endtask

    task automatic t_nofit();
        logic [23:0] prev_word;
        logic [31:0] prev_ach;
        prev_word = pll_word;
        prev_ach  = achieved_khz;
        kick(50000, 5000, 128000, 350000, 350000);
        wait_done("R9 nofit");
        chk("R9 no_fit flag", no_fit, 1);
        chk("R9 word kept", pll_word, prev_word);
        chk("R9 achieved kept", achieved_khz, prev_ach);
        @(negedge clk);
        chk("R8 word holds after done", pll_word, prev_word);
    endtask

    task automatic t_busy_start();
        kick(65000, 14318, 128000, 350000, 350000);
        repeat (5) @(negedge clk);
        req_khz = 32'd40000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 still busy", busy, 1);
        wait_done("R10 ignore");
        check_result("R10 ignore", 65000, 14318, 128000, 350000, 350000);
        chk("R10 not busy at done", busy, 0);
    endtask

    task automatic t_vco_gate();
        kick(20000, 14318, 160000, 160000, 350000);
        wait_done("R2 gate");
        check_result("R2 gate", 20000, 14318, 160000, 160000, 350000);
        chk("R2 only P=8 legal", p_code, 3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_normal("R3 25175", 25175);
        t_normal("R4 108000", 108000);
        t_normal("R5 65000", 65000);
        t_clamp_low();
        t_clamp_high();
        t_tie();
        t_nofit();
        t_busy_start();
        t_vco_gate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule